// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the system reset for a board-level controller. It drives two reset pad enables that always agree: one pad is asserted high, the other asserted low. Both pads are meant for open-drain drivers. Three causes hold reset: the supply-good flag from an outside comparator is low, the supply has just come up, or a watchdog has expired. The watchdog is serviced by activity on a chip-select line. Each transition of that line, rising or falling, restarts the count.

The two reset pads are also read back. An external agent that pulls either pad into its asserted state starts a fresh reset stretch, so the block also works as a reset conditioner and extender. Pad senses and chip select pass through a two-flop synchronizer before their edges are detected. Edges that arrive while the block is itself driving reset are ignored, so the block's own drive on the pads cannot retrigger it. Every duration is counted in ticks from a single free-running prescaler. The stretch and watchdog periods are parameters in ticks. The defaults give a 1 ms tick at 125 MHz, a 150 ms stretch and a 1.6 s watchdog. `supply_ok` is taken to be synchronous to `clk`, and `rst_n` is taken to be released synchronously upstream.

Top module: `reset_supervisor`

## Requirements
- R1: While `supply_ok` is low, `rst_hi_drv` is 1 and `rst_lo_n_drv` is 0. The path is combinational, so this holds in the same cycle the flag falls.
- R2: The prescaler emits one tick every TICK_DIV clock edges. After `supply_ok` rises, reset stays asserted and is released on edge k after the rise, with k in [(STRETCH_TICKS-1)*TICK_DIV+1, STRETCH_TICKS*TICK_DIV].
- R3: If chip select stops changing, reset asserts on edge k after its last change, with k in [(WDOG_TICKS-1)*TICK_DIV+4, WDOG_TICKS*TICK_DIV+3]. Reset then holds for a stretch of the length given in R2.
- R4: Every rising or falling transition of `csel` restarts the watchdog. If no gap between transitions exceeds (WDOG_TICKS-1)*TICK_DIV edges, reset never asserts.
- R5: A 0-to-1 edge on `pad_hi_sense` that occurs while reset is released asserts reset on the third clock edge after it. Reset then holds for the R2 stretch length, counted from that edge.
- R6: A 1-to-0 edge on `pad_lo_n_sense` that occurs while reset is released has the same effect and timing as R5.
- R7: The watchdog is held cleared while reset is driven and while either pad sense is in its asserted state (`pad_hi_sense`=1 or `pad_lo_n_sense`=0). After the later of the two ends, the timeout arrives on edge k in [(WDOG_TICKS-1)*TICK_DIV+3, WDOG_TICKS*TICK_DIV+2], counted from the end of the stretch or from the release of the pad.
- R8: Pad edges that arrive while reset is already driven, including the edges the block's own drive creates, do not restart or extend the stretch.
- R9: `rst_lo_n_drv` is always the inverse of `rst_hi_drv`.
- R10: While `rst_n` is low, reset is asserted. After `rst_n` is released with `supply_ok` high, the R2 stretch applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok | input | 1 | Supply-good flag from the external comparator |
| pad_hi_sense | input | 1 | Read-back of the active-high reset pad |
| pad_lo_n_sense | input | 1 | Read-back of the active-low reset pad |
| csel | input | 1 | Chip select; any transition services the watchdog |
| rst_hi_drv | output | 1 | Active-high reset (open-drain pad enable) |
| rst_lo_n_drv | output | 1 | Active-low reset (open-drain pad enable) |

## Verification
The supply path has no register, so R1 is sampled 1 ns after `supply_ok` falls, inside the same cycle. Pad and chip-select inputs pass through two synchronizer flops and one edge register. Their effect on reset is therefore sampled exactly at the third edge, and is checked to be still absent at the second. The free-running prescaler's phase is not known to the bench, so each stretch and timeout is measured in clock edges from its cause and compared against a window exactly one tick period wide, as the requirements state it. The bench models the open-drain pads as wired-OR with its own pulls, so the block's own drive returns to it as pad edges. That is how R8 is exercised.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  // Width of a counter that must hold values 0 .. n-1.
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Synchronized sense bits, in a fixed bit order.
  typedef struct packed {
    logic hi;    // active-high pad read-back
    logic lo_n;  // active-low pad read-back
    logic cs;    // chip select
  } sense_t;

  // The pads read as asserted in reset, so no false edge appears on release.
  localparam sense_t SENSE_RST = '{hi: 1'b1, lo_n: 1'b0, cs: 1'b0};

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[b];
        s2_q <= RST_VAL[b];
      end else begin
        s1_q <= d[b];
        s2_q <= s1_q;
      end
    end
    assign q[b] = s2_q;
  end

endmodule

// File: rtl/rsup_prescale.sv
module rsup_prescale #(
  parameter int   DIV = 125000,
  localparam int  PW  = rsup_pkg::cnt_w(DIV)
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
  parameter int   TICKS = 150,
  localparam int  CW    = rsup_pkg::cnt_w(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          tick,
  input  logic          trig,
  output logic          busy,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  // The register only changes on a restart cause or on a tick while busy.
  assign en = !supply_ok || trig || (busy_q && tick);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!supply_ok || trig) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q == LAST) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog #(
  parameter int   TICKS = 1600,
  localparam int  CW    = rsup_pkg::cnt_w(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  output logic          timeout,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign timeout = tick && !clr && (cnt_q == LAST);
  assign en      = clr || tick;

  always_comb begin
    if (clr || timeout) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int TICK_DIV      = 125000,
  parameter int STRETCH_TICKS = 150,
  parameter int WDOG_TICKS    = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pad_hi_sense,
  input  logic pad_lo_n_sense,
  input  logic csel,
  output logic rst_hi_drv,
  output logic rst_lo_n_drv
);

  import rsup_pkg::*;

  localparam int ST_W = cnt_w(STRETCH_TICKS);
  localparam int WD_W = cnt_w(WDOG_TICKS);

  sense_t raw, sync_s, prev_q;
  logic   tick;
  logic   stretch_busy, stretch_trig;
  logic   [ST_W-1:0] st_cnt;
  logic   [WD_W-1:0] wd_cnt;
  logic   wd_timeout, wd_clr;
  logic   drive;
  logic   ext_edge, ext_level, cs_edge;

  assign raw = '{hi: pad_hi_sense, lo_n: pad_lo_n_sense, cs: csel};

  rsup_sync #(.W($bits(sense_t)), .RST_VAL(SENSE_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (sync_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= SENSE_RST;
    else        prev_q <= sync_s;
  end

  assign ext_edge  = (sync_s.hi & ~prev_q.hi) | (~sync_s.lo_n & prev_q.lo_n);
  assign ext_level = sync_s.hi | ~sync_s.lo_n;
  assign cs_edge   = sync_s.cs ^ prev_q.cs;

  rsup_prescale #(.DIV(TICK_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  assign drive        = ~supply_ok | stretch_busy;
  assign stretch_trig = (ext_edge & ~drive) | wd_timeout;

  rsup_stretch #(.TICKS(STRETCH_TICKS)) u_stretch (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .tick      (tick),
    .trig      (stretch_trig),
    .busy      (stretch_busy),
    .cnt       (st_cnt)
  );

  assign wd_clr = ~supply_ok | stretch_busy | ext_level | cs_edge;

  rsup_watchdog #(.TICKS(WDOG_TICKS)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clr     (wd_clr),
    .timeout (wd_timeout),
    .cnt     (wd_cnt)
  );

  assign rst_hi_drv   = drive;
  assign rst_lo_n_drv = ~drive;

endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
  parameter int   ST_TICKS = 150,
  parameter int   WD_TICKS = 1600,
  localparam int  SW       = rsup_pkg::cnt_w(ST_TICKS),
  localparam int  WW       = rsup_pkg::cnt_w(WD_TICKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          rst_hi_drv,
  input logic          rst_lo_n_drv,
  input logic          busy,
  input logic [SW-1:0] st_cnt,
  input logic [WW-1:0] wd_cnt,
  input logic          wd_timeout,
  input logic          cs_edge,
  input logic          ext_level
);

  // R9
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hi_drv != rst_lo_n_drv);

  // R1
  supply_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> rst_hi_drv);

  // R2
  supply_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |-> rst_hi_drv);

  // R2
  stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(st_cnt) < ST_TICKS);

  // R3
  timeout_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> rst_hi_drv);

  // R3
  wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wd_cnt) < WD_TICKS);

  // R4
  cs_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_edge |=> wd_cnt == '0);

  // R7
  wdog_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> wd_cnt == '0);

  // R7
  wdog_hold_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_level |=> wd_cnt == '0);

endmodule

bind reset_supervisor rsup_checker #(
  .ST_TICKS (STRETCH_TICKS),
  .WD_TICKS (WDOG_TICKS)
) u_rsup_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ok    (supply_ok),
  .rst_hi_drv   (rst_hi_drv),
  .rst_lo_n_drv (rst_lo_n_drv),
  .busy         (stretch_busy),
  .st_cnt       (st_cnt),
  .wd_cnt       (wd_cnt),
  .wd_timeout   (wd_timeout),
  .cs_edge      (cs_edge),
  .ext_level    (ext_level)
);

// File: tb/tb_reset_supervisor.sv
`timescale 1ns/1ps
module tb_reset_supervisor;

  localparam int P = 4;
  localparam int S = 5;
  localparam int W = 12;

  localparam int ST_LO = (S - 1) * P + 1;
  localparam int ST_HI = S * P;

  logic clk = 1'b0;
  logic rst_n, supply_ok, csel, ext_hi, ext_lo;
  logic rst_hi_drv, rst_lo_n_drv;
  logic pad_hi, pad_lo_n;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  // Open-drain pads: wired with the external agent's pulls.
  assign pad_hi   = rst_hi_drv | ext_hi;
  assign pad_lo_n = rst_lo_n_drv & ~ext_lo;

  reset_supervisor #(
    .TICK_DIV      (P),
    .STRETCH_TICKS (S),
    .WDOG_TICKS    (W)
  ) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .pad_hi_sense   (pad_hi),
    .pad_lo_n_sense (pad_lo_n),
    .csel           (csel),
    .rst_hi_drv     (rst_hi_drv),
    .rst_lo_n_drv   (rst_lo_n_drv)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic check_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int wd_lo(input int lat);
    return (W - 1) * P + 1 + lat;
  endfunction

  function automatic int wd_hi(input int lat);
    return W * P + lat;
  endfunction

  // Count falling edges until rst_hi_drv equals want; -1 on no change.
  task automatic wait_level(input logic want, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (rst_hi_drv !== want && n < 2000);
    if (rst_hi_drv !== want) n = -1;
  endtask

  task automatic kick();
    @(negedge clk);
    csel = ~csel;
    repeat (4) @(negedge clk);
  endtask

  // R9 on every cycle
  always @(negedge clk) begin
    if (rst_n && !done)
      check(rst_hi_drv !== rst_lo_n_drv && !$isunknown(rst_hi_drv), "R9",
            int'(rst_lo_n_drv), int'(~rst_hi_drv));
  end

  task automatic supply_cycle(input int hold);
    int n;
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    check(rst_hi_drv === 1'b1 && rst_lo_n_drv === 1'b0, "R1 same-cycle", int'(rst_hi_drv), 1);
    repeat (hold) @(negedge clk);
    check(rst_hi_drv === 1'b1, "R1 held", int'(rst_hi_drv), 1);
    supply_ok = 1'b1;
    wait_level(1'b0, n);
    check_win("R2 power-up stretch", n, ST_LO, ST_HI);
  endtask

  // R5 (hi pad) or R6 (lo pad); optional second edge inside the stretch for R8
  task automatic pad_pulse(input bit use_lo, input bit extra);
    int n;
    string req;
    req = use_lo ? "R6" : "R5";
    kick();
    if (use_lo) ext_lo = 1'b1; else ext_hi = 1'b1;
    @(negedge clk);
    ext_lo = 1'b0;
    ext_hi = 1'b0;
    @(negedge clk);
    check(rst_hi_drv === 1'b0, {req, " not before edge 3"}, int'(rst_hi_drv), 0);
    @(negedge clk);
    check(rst_hi_drv === 1'b1, {req, " asserted at edge 3"}, int'(rst_hi_drv), 1);
    if (extra) begin
      repeat (8) @(negedge clk);
      if (use_lo) ext_hi = 1'b1; else ext_lo = 1'b1;
      @(negedge clk);
      ext_lo = 1'b0;
      ext_hi = 1'b0;
      wait_level(1'b0, n);
      check_win("R8 edge during stretch ignored", n + 9, ST_LO, ST_HI);
    end else begin
      wait_level(1'b0, n);
      check_win({req, " stretch length"}, n, ST_LO, ST_HI);
    end
  endtask

  // R4: random gaps no longer than the safe bound
  task automatic cs_burst(input int count);
    bit quiet;
    quiet = 1'b1;
    kick();
    for (int i = 0; i < count; i++) begin
      int gap;
      gap = $urandom_range(1, (W - 1) * P);
      csel = ~csel;
      for (int j = 0; j < gap; j++) begin
        @(negedge clk);
        if (rst_hi_drv !== 1'b0) quiet = 1'b0;
      end
    end
    check(quiet, "R4 no timeout with regular kicks", int'(!quiet), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL run-time limit: actual hung expected completion");
    finish_run();
  end

  initial begin
    int n;
    bit quiet;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; supply_ok = 1'b0; csel = 1'b0; ext_hi = 1'b0; ext_lo = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_hi_drv === 1'b1 && rst_lo_n_drv === 1'b0, "R10 reset state", int'(rst_hi_drv), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rst_hi_drv === 1'b1, "R1 supply low after reset", int'(rst_hi_drv), 1);

    // R2 power-up, then R7 hold through stretch and the R3 timeout that follows
    supply_ok = 1'b1;
    wait_level(1'b0, n);
    check_win("R2 first power-up", n, ST_LO, ST_HI);
    wait_level(1'b1, n);
    check_win("R7 timeout counted from stretch end", n, wd_lo(2), wd_hi(2));
    wait_level(1'b0, n);
    check_win("R3 stretch after timeout", n, ST_LO, ST_HI);

    // R10: reset in mid-operation, released with supply good
    kick();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rst_hi_drv === 1'b1, "R10 async assert", int'(rst_hi_drv), 1);
    @(negedge clk);
    rst_n = 1'b1;
    wait_level(1'b0, n);
    check_win("R10 stretch after reset", n, ST_LO, ST_HI);

    // Directed cases, then a random mix
    pad_pulse(1'b0, 1'b0);
    pad_pulse(1'b1, 1'b0);
    pad_pulse(1'b0, 1'b1);
    pad_pulse(1'b1, 1'b1);
    supply_cycle(1);
    for (int i = 0; i < 16; i++) begin
      int kind;
      kind = $urandom_range(0, 3);
      case (kind)
        0: supply_cycle($urandom_range(1, 10));
        1: cs_burst($urandom_range(5, 15));
        2: pad_pulse(1'b0, 1'($urandom_range(0, 1)));
        default: pad_pulse(1'b1, 1'($urandom_range(0, 1)));
      endcase
    end

    // R3: chip select stops
    kick();
    @(negedge clk);
    csel = ~csel;
    wait_level(1'b1, n);
    check_win("R3 timeout after last kick", n, wd_lo(3), wd_hi(3));
    wait_level(1'b0, n);
    check_win("R3 timeout stretch", n, ST_LO, ST_HI);

    // R7: pad held asserted far longer than the watchdog period
    kick();
    ext_hi = 1'b1;
    quiet = 1'b1;
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (i > 3 + ST_HI + 1 && rst_hi_drv !== 1'b0) quiet = 1'b0;
    end
    check(quiet, "R7 held pad keeps watchdog clear", int'(!quiet), 0);
    ext_hi = 1'b0;
    wait_level(1'b1, n);
    check_win("R7 timeout counted from pad release", n, wd_lo(2), wd_hi(2));
    wait_level(1'b0, n);
    check_win("R3 stretch after pad-hold timeout", n, ST_LO, ST_HI);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule